// File: doc/BRIEF.md
# Scheduled Periodic Pin Output

This block drives one output pin from a free-running time counter. After software loads a 64-bit launch time and a 32-bit half-period, both in counter ticks, a start pulse arms the block. The pin toggles when the counter reaches the launch time. After that it toggles once every half-period, which gives a square wave with a 50% duty cycle. Its frequency is 1e9 / (half_period × tick_ns × 2).

Every edge is placed by comparing the live counter value against an accumulated edge time, not by counting clock cycles. Rate trims and time steps applied to the counter therefore move the pin edges with it. A start pulse whose launch time is not strictly in the future is dropped. A stop pulse freezes the pin at its present level and discards the schedule.

Top module: `sched_pin_out`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `pin_out` is 0 and no edge is scheduled.
- R2: A start pulse is accepted only when `launch_time` is strictly greater than `now_time`, both compared as unsigned 64-bit values. Any other start pulse has no effect: an idle block stays idle, and a running schedule carries on unchanged.
- R3: After a start is accepted, `pin_out` inverts in the cycle after the first clock edge at which `now_time >= launch_time`. The output is registered.
- R4: Each later toggle happens on the first edge at which `now_time` reaches the previous edge time plus `half_period`. This gives a 50% duty cycle.
- R5: A stop pulse discards any pending edge. `pin_out` then holds its current level until a new start is accepted.
- R6: If start and stop pulse in the same cycle, stop wins and the start is dropped.
- R7: If `now_time` steps forward past several scheduled edges, the pin toggles once per clock until the scheduled edge time is greater than `now_time`. If `now_time` steps backward, no toggle occurs until `now_time` reaches the scheduled edge again.
- R8: `half_period` is added at the moment of each toggle. A change to it leaves the edge that is already scheduled unchanged and applies to the edges that follow.
- R9: An accepted start while running replaces the schedule. The old pending edge is dropped, and the pin keeps its level until the new launch time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| now_time | input | 64 | Live time counter, in ticks |
| launch_time | input | 64 | Absolute time of the first toggle |
| half_period | input | 32 | Ticks between consecutive edges |
| start_cmd | input | 1 | One-cycle start pulse |
| stop_cmd | input | 1 | One-cycle stop pulse |
| pin_out | output | 1 | Pin level |

## Verification
The hardest case to reach from the ports is catch-up after a forward time step. The scheduled edge falls several half-periods behind the counter, and the pin then has to toggle on consecutive clocks while the accumulated edge time walks forward. The bench drives `now_time` directly, not as a free-running count. It holds the counter at a value several half-periods ahead of the scheduled edge and checks the pin after every clock. It then steps the counter backward to confirm that the pin waits. A separate case places launch and current time on opposite sides of a 32-bit carry, so that the upper word decides whether a start is accepted.

// File: rtl/sched_pin_pkg.sv
package sched_pin_pkg;
  typedef enum logic [1:0] {
    SP_IDLE  = 2'd0,
    SP_ARMED = 2'd1,
    SP_RUN   = 2'd2
  } sp_state_e;
endpackage

// File: rtl/time_cmp.sv
// Unsigned magnitude comparator; STRICT picks > versus >=.
module time_cmp #(
  parameter int W      = 64,
  parameter bit STRICT = 1'b0
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  output logic         hit
);
  generate
    if (STRICT) begin : g_gt
      assign hit = (lhs > rhs);
    end else begin : g_ge
      assign hit = (lhs >= rhs);
    end
  endgenerate
endmodule

// File: rtl/pin_sched_fsm.sv
// Holds the schedule state and the accumulated time of the next edge.
module pin_sched_fsm
  import sched_pin_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int DUR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_cmd,
  input  logic              stop_cmd,
  input  logic              launch_future,
  input  logic              edge_due,
  input  logic [TIME_W-1:0] launch_time,
  input  logic [DUR_W-1:0]  half_period,
  output sp_state_e         state,
  output logic [TIME_W-1:0] edge_time,
  output logic              toggle_en
);
  localparam int PAD_W = TIME_W - DUR_W;

  logic accept_start;
  logic active;
  logic [TIME_W-1:0] dur_ext;

  assign dur_ext      = {{PAD_W{1'b0}}, half_period};
  assign accept_start = start_cmd && launch_future && !stop_cmd;
  assign active       = (state != SP_IDLE);
  assign toggle_en    = active && edge_due && !stop_cmd && !accept_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SP_IDLE;
      edge_time <= '0;
    end else if (stop_cmd) begin
      state <= SP_IDLE;
    end else if (accept_start) begin
      state     <= SP_ARMED;
      edge_time <= launch_time;
    end else if (toggle_en) begin
      state     <= SP_RUN;
      edge_time <= edge_time + dur_ext;
    end
  end
endmodule

// File: rtl/pin_level_reg.sv
// Registered pin level, inverted on request.
module pin_level_reg (
  input  logic clk,
  input  logic rst,
  input  logic toggle_en,
  output logic level
);
  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
    end else if (toggle_en) begin
      level <= ~level;
    end
  end
endmodule

// File: rtl/sched_pin_out.sv
module sched_pin_out
  import sched_pin_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int DUR_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] now_time,
  input  logic [TIME_W-1:0] launch_time,
  input  logic [DUR_W-1:0]  half_period,
  input  logic              start_cmd,
  input  logic              stop_cmd,
  output logic              pin_out
);
  sp_state_e         fsm_state;
  logic [TIME_W-1:0] edge_time;
  logic              launch_future;
  logic              edge_due;
  logic              toggle_en;

  time_cmp #(.W(TIME_W), .STRICT(1'b1)) u_launch_cmp (
    .lhs(launch_time),
    .rhs(now_time),
    .hit(launch_future)
  );

  time_cmp #(.W(TIME_W), .STRICT(1'b0)) u_edge_cmp (
    .lhs(now_time),
    .rhs(edge_time),
    .hit(edge_due)
  );

  pin_sched_fsm #(.TIME_W(TIME_W), .DUR_W(DUR_W)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .start_cmd    (start_cmd),
    .stop_cmd     (stop_cmd),
    .launch_future(launch_future),
    .edge_due     (edge_due),
    .launch_time  (launch_time),
    .half_period  (half_period),
    .state        (fsm_state),
    .edge_time    (edge_time),
    .toggle_en    (toggle_en)
  );

  pin_level_reg u_level (
    .clk      (clk),
    .rst      (rst),
    .toggle_en(toggle_en),
    .level    (pin_out)
  );
endmodule

// File: rtl/sched_pin_out_chk.sv
module sched_pin_out_chk
  import sched_pin_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              start_cmd,
  input logic              stop_cmd,
  input logic [TIME_W-1:0] now_time,
  input logic [TIME_W-1:0] launch_time,
  input logic              pin_out,
  input sp_state_e         state,
  input logic [TIME_W-1:0] edge_time
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!pin_out && state == SP_IDLE));

  assert_past_start_dropped_R2: assert property (@(posedge clk) disable iff (rst)
    (start_cmd && !stop_cmd && state == SP_IDLE && launch_time <= now_time)
      |=> (state == SP_IDLE));

  assert_start_arms_R9: assert property (@(posedge clk) disable iff (rst)
    (start_cmd && !stop_cmd && launch_time > now_time)
      |=> (state == SP_ARMED && edge_time == $past(launch_time) && $stable(pin_out)));

  assert_due_edge_toggles_R3: assert property (@(posedge clk) disable iff (rst)
    (state != SP_IDLE && !start_cmd && !stop_cmd && now_time >= edge_time)
      |=> (pin_out != $past(pin_out)));

  assert_stop_idles_R5: assert property (@(posedge clk) disable iff (rst)
    stop_cmd |=> (state == SP_IDLE && $stable(pin_out)));

  assert_idle_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (state == SP_IDLE) |=> $stable(pin_out));
endmodule

bind sched_pin_out sched_pin_out_chk #(.TIME_W(TIME_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_cmd  (start_cmd),
  .stop_cmd   (stop_cmd),
  .now_time   (now_time),
  .launch_time(launch_time),
  .pin_out    (pin_out),
  .state      (fsm_state),
  .edge_time  (edge_time)
);

// File: tb/test_sched_pin_out.sv
`timescale 1ns/1ps
module test_sched_pin_out;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] now_time = '0;
  logic [63:0] launch_time = '0;
  logic [31:0] half_period = '0;
  logic        start_cmd = 1'b0;
  logic        stop_cmd = 1'b0;
  logic        pin_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sched_pin_out i_sched_pin_out (
    .clk(clk), .rst(rst), .now_time(now_time), .launch_time(launch_time),
    .half_period(half_period), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .pin_out(pin_out)
  );

  // Present time and commands at the falling edge, sample just after the rising edge.
  task automatic step(input logic [63:0] t, input logic st, input logic sp);
    @(negedge clk);
    now_time  = t;
    start_cmd = st;
    stop_cmd  = sp;
    @(posedge clk);
    #1;
    start_cmd = 1'b0;
    stop_cmd  = 1'b0;
  endtask

  task automatic chk(input logic exp, input string req);
    checks++;
    if (pin_out !== exp) begin
      failures++;
      $display("FAIL %s: pin_out=%0b expected=%0b at now=%0d", req, pin_out, exp, now_time);
    end
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1; chk(1'b0, "R1 during reset");
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1; chk(1'b0, "R1 after reset");
    step(64'd50, 1'b0, 1'b0); chk(1'b0, "R1 no schedule");
  endtask

  task automatic t_basic;
    launch_time = 64'd110; half_period = 32'd5;
    step(64'd100, 1'b1, 1'b0); chk(1'b0, "R3 armed");
    step(64'd109, 1'b0, 1'b0); chk(1'b0, "R3 before launch");
    step(64'd110, 1'b0, 1'b0); chk(1'b1, "R3 first edge");
    step(64'd114, 1'b0, 1'b0); chk(1'b1, "R4 high half");
    step(64'd115, 1'b0, 1'b0); chk(1'b0, "R4 second edge");
    step(64'd119, 1'b0, 1'b0); chk(1'b0, "R4 low half");
    step(64'd120, 1'b0, 1'b0); chk(1'b1, "R4 third edge");
    step(64'd121, 1'b0, 1'b1); chk(1'b1, "R5 stop holds");
  endtask

  task automatic t_ignore;
    launch_time = 64'd200;
    step(64'd200, 1'b1, 1'b0); chk(1'b1, "R2 equal time");
    step(64'd205, 1'b0, 1'b0); chk(1'b1, "R2 equal time ignored");
    launch_time = 64'd150;
    step(64'd300, 1'b1, 1'b0);
    step(64'd400, 1'b0, 1'b0); chk(1'b1, "R2 past time ignored");
    launch_time = 64'd410; half_period = 32'd10;
    step(64'd400, 1'b1, 1'b0);
    step(64'd410, 1'b0, 1'b0); chk(1'b0, "R3 run edge");
    launch_time = 64'd405;
    step(64'd412, 1'b1, 1'b0);
    step(64'd419, 1'b0, 1'b0); chk(1'b0, "R2 running unchanged");
    step(64'd420, 1'b0, 1'b0); chk(1'b1, "R2 schedule continues");
    step(64'd421, 1'b0, 1'b1);
  endtask

  task automatic t_stop;
    launch_time = 64'd505; half_period = 32'd4;
    step(64'd500, 1'b1, 1'b0);
    step(64'd505, 1'b0, 1'b0); chk(1'b0, "R4 stop setup");
    step(64'd509, 1'b0, 1'b0); chk(1'b1, "R4 stop setup");
    step(64'd513, 1'b0, 1'b1); chk(1'b1, "R5 stop beats due edge");
    step(64'd517, 1'b0, 1'b0); chk(1'b1, "R5 no edge after stop");
    step(64'd600, 1'b0, 1'b0); chk(1'b1, "R5 level held");
  endtask

  task automatic t_collide;
    launch_time = 64'd710;
    step(64'd700, 1'b1, 1'b1);
    step(64'd710, 1'b0, 1'b0); chk(1'b1, "R6 start dropped");
    step(64'd720, 1'b0, 1'b0); chk(1'b1, "R6 still idle");
  endtask

  task automatic t_jump;
    launch_time = 64'd810; half_period = 32'd10;
    step(64'd800, 1'b1, 1'b0);
    step(64'd810, 1'b0, 1'b0); chk(1'b0, "R7 setup");
    step(64'd851, 1'b0, 1'b0); chk(1'b1, "R7 catch-up 1");
    step(64'd851, 1'b0, 1'b0); chk(1'b0, "R7 catch-up 2");
    step(64'd851, 1'b0, 1'b0); chk(1'b1, "R7 catch-up 3");
    step(64'd851, 1'b0, 1'b0); chk(1'b0, "R7 catch-up 4");
    step(64'd851, 1'b0, 1'b0); chk(1'b0, "R7 caught up");
    step(64'd859, 1'b0, 1'b0); chk(1'b0, "R7 before 860");
    step(64'd860, 1'b0, 1'b0); chk(1'b1, "R7 edge 860");
    step(64'd700, 1'b0, 1'b0); chk(1'b1, "R7 backward step waits");
    step(64'd869, 1'b0, 1'b0); chk(1'b1, "R7 backward still waits");
    step(64'd870, 1'b0, 1'b0); chk(1'b0, "R7 edge 870");
    step(64'd871, 1'b0, 1'b1);
  endtask

  task automatic t_dur_change;
    launch_time = 64'd1010; half_period = 32'd10;
    step(64'd1000, 1'b1, 1'b0);
    step(64'd1010, 1'b0, 1'b0); chk(1'b1, "R8 first edge");
    half_period = 32'd3;
    step(64'd1015, 1'b0, 1'b0); chk(1'b1, "R8 scheduled edge kept");
    step(64'd1020, 1'b0, 1'b0); chk(1'b0, "R8 old-period edge");
    step(64'd1022, 1'b0, 1'b0); chk(1'b0, "R8 new period pending");
    step(64'd1023, 1'b0, 1'b0); chk(1'b1, "R8 new-period edge");
    step(64'd1024, 1'b0, 1'b1);
  endtask

  task automatic t_restart;
    launch_time = 64'd1105; half_period = 32'd5;
    step(64'd1100, 1'b1, 1'b0);
    step(64'd1105, 1'b0, 1'b0); chk(1'b0, "R9 setup");
    launch_time = 64'd1200;
    step(64'd1107, 1'b1, 1'b0); chk(1'b0, "R9 restart holds");
    step(64'd1110, 1'b0, 1'b0); chk(1'b0, "R9 old edge dropped");
    step(64'd1199, 1'b0, 1'b0); chk(1'b0, "R9 waiting");
    step(64'd1200, 1'b0, 1'b0); chk(1'b1, "R9 new launch edge");
    step(64'd1201, 1'b0, 1'b1);
  endtask

  task automatic t_wide;
    launch_time = 64'h0000_0002_0000_0000 - 64'd1; half_period = 32'd8;
    step(64'h0000_0002_0000_0000, 1'b1, 1'b0);
    step(64'h0000_0002_0000_0100, 1'b0, 1'b0); chk(1'b1, "R2 upper word rejects");
    launch_time = 64'h0000_0001_0000_0000;
    step(64'h0000_0000_FFFF_FFF0, 1'b1, 1'b0); chk(1'b1, "R2 upper word accepts");
    step(64'h0000_0000_FFFF_FFFF, 1'b0, 1'b0); chk(1'b1, "R3 not yet");
    step(64'h0000_0001_0000_0000, 1'b0, 1'b0); chk(1'b0, "R3 edge across carry");
    step(64'h0000_0001_0000_0008, 1'b0, 1'b0); chk(1'b1, "R4 edge across carry");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_ignore();
    t_stop();
    t_collide();
    t_jump();
    t_dur_change();
    t_restart();
    t_wide();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule